// File: doc/BRIEF.md
# Tone Beep Sequencer

This block turns a beep request into the byte-wide bus traffic that makes an attached interval timer produce a tone on a speaker. A request carries a tone frequency in hertz and a duration measured in ticks. The block first computes the timer reload count with a bit-serial divider. It then programs the timer's third counter for a 16-bit square-wave reload over an I/O bus master and switches the speaker on with a read-modify-write of the speaker control port. Once the duration has run out, it switches the speaker off with a second read-modify-write.

A request that arrives while a tone is sounding cancels the pending stop. When the new frequency matches the one stored from the previous request, the block reprograms nothing and only restarts the duration countdown with the new length. When the frequency differs, it recomputes and rewrites the reload count and restarts the countdown. A zero frequency is refused and flagged, because it would divide by zero.

States: `ST_IDLE` (no tone), `ST_DIVIDE` (divider running), `ST_WR_CTRL` (control byte write), `ST_WR_LO` (count low byte), `ST_WR_HI` (count high byte), `ST_RD_ON` (read speaker port), `ST_WR_ON` (write speaker port with gate and data set), `ST_SOUNDING` (tone on, countdown running), `ST_RD_OFF` (read speaker port), `ST_WR_OFF` (write speaker port with both bits cleared). Transitions: IDLE or SOUNDING to DIVIDE on an accepted non-zero request, except a same-frequency request in SOUNDING, which stays in SOUNDING; DIVIDE to WR_CTRL when the divider finishes; every bus state moves to the next one on `bus_ack` (WR_CTRL, WR_LO, WR_HI, RD_ON, WR_ON, SOUNDING); SOUNDING to RD_OFF when the countdown is zero and no request is accepted; RD_OFF to WR_OFF to IDLE on `bus_ack`.

Top module: `tone_beep_ctrl`

## Requirements
- R1: The reload count is floor((1193182 + floor(f/2)) / f), taken modulo 65536, where f is the requested frequency.
- R2: Programming is three bus writes in this order: byte 0xB6 to the timer base + 3, then count[7:0] to base + 2, then count[15:8] to base + 2. With the default base 0x40 these addresses are 0x43 and 0x42.
- R3: To start the tone, the block reads port 0x61, then writes back the value read with bits 0 and 1 set and all other bits unchanged. `beep_active` rises when that write is acknowledged.
- R4: While a tone sounds, the countdown is loaded with the duration and decrements on each cycle with `tick` high. When it reaches zero, the block reads port 0x61 and writes it back with bits 0 and 1 cleared and all other bits kept. `beep_active` falls when that write is acknowledged.
- R5: A request with the same frequency as the stored one, accepted while sounding, causes no bus traffic and restarts the countdown with the new duration.
- R6: A request with a different frequency, accepted while sounding, rewrites the reload count and then runs the full duration of the new request.
- R7: A request with frequency 0 causes no bus traffic and no state change. `req_err` is high for exactly the one cycle after that request is accepted.
- R8: The bus master has at most one transaction open at a time. It holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack`.
- R9: `req_ready` is high only in IDLE and SOUNDING. It is low while the divider or any bus transaction is in progress.
- R10: After reset, `bus_req`, `beep_active` and `req_err` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Beep request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_freq | input | 16 | Tone frequency in Hz |
| req_dur | input | 16 | Tone length in ticks |
| tick | input | 1 | Single-cycle duration time base |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | I/O port address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transaction done; read data valid |
| bus_rdata | input | 8 | Read data |
| beep_active | output | 1 | Tone is sounding |
| req_err | output | 1 | Zero-frequency request refused |

## Verification
The hardest situation to reach from the ports is a retrigger that arrives while a tone is sounding part of the way through its countdown. The bench must tell apart a countdown that restarts from one that continues, and a skipped reprogramming from a repeated one. The stimulus starts a tone, spends some ticks, and then sends a request with the same frequency or a different one. It then counts the ticks needed before the tone stops and counts how many timer programming sequences the bus model received. Random frequencies, random acknowledge latency and varied speaker port contents cover the divider rounding and the preservation of the other speaker bits.

// File: rtl/beep_pkg.sv
package beep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_WR_CTRL,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_ON,
        ST_WR_ON,
        ST_SOUNDING,
        ST_RD_OFF,
        ST_WR_OFF
    } beep_state_t;

    localparam logic [7:0] SQWAVE_CTRL = 8'hB6;
    localparam logic [7:0] SPK_BITS    = 8'h03;
endpackage

// File: rtl/beep_divider.sv
module beep_divider #(
    parameter int NUM_W = 21,
    parameter int DEN_W = 16,
    parameter int NUMER = 1193182
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  shift_q;
    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              done_q;
    logic [DEN_W:0]    trial;
    logic [DEN_W:0]    diff;
    logic              fits;

    // restoring step: bring down one dividend bit, subtract if it fits
    always_comb begin
        trial = {rem_q, shift_q[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            step_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                // rounding bias: add half the divisor to the dividend
                shift_q <= NUM_W'(NUMER) + NUM_W'(den >> 1);
                rem_q   <= '0;
                den_q   <= den;
                step_q  <= STEP_W'(NUM_W);
                busy_q  <= 1'b1;
            end else if (busy_q) begin
                rem_q   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                shift_q <= {shift_q[NUM_W-2:0], fits};
                step_q  <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = shift_q;
endmodule

// File: rtl/beep_duration.sv
module beep_duration #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expired
);
    logic [DUR_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (run && tick && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired = (left_q == '0);
endmodule

// File: rtl/tone_beep_ctrl.sv
module tone_beep_ctrl
    import beep_pkg::*;
#(
    parameter int          FREQ_W    = 16,
    parameter int          DUR_W     = 16,
    parameter int          CNT_W     = 16,
    parameter int          NUM_W     = 21,
    parameter int          NUMER     = 1193182,
    parameter logic [7:0]  TMR_BASE  = 8'h40,
    parameter logic [7:0]  SPK_PORT  = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FREQ_W-1:0] req_freq,
    input  logic [DUR_W-1:0]  req_dur,
    input  logic              tick,
    output logic              bus_req,
    output logic              bus_we,
    output logic [7:0]        bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              beep_active,
    output logic              req_err
);
    localparam logic [7:0] CTRL_ADDR = TMR_BASE + 8'd3;
    localparam logic [7:0] CNT2_ADDR = TMR_BASE + 8'd2;

    beep_state_t state_q, state_d;

    logic [FREQ_W-1:0] last_freq_q;
    logic [DUR_W-1:0]  last_dur_q;
    logic [CNT_W-1:0]  count_q;
    logic [7:0]        spk_q;
    logic              active_q;
    logic              err_q;

    logic              accept;
    logic              zero_req;
    logic              same_pitch;
    logic              new_pitch;
    logic              div_busy;
    logic              div_done;
    logic [NUM_W-1:0]  div_quot;
    logic              dur_load;
    logic [DUR_W-1:0]  dur_val;
    logic              dur_expired;

    assign accept     = req_valid && req_ready;
    assign zero_req   = accept && (req_freq == '0);
    assign same_pitch = accept && !zero_req && (state_q == ST_SOUNDING)
                        && (req_freq == last_freq_q);
    assign new_pitch  = accept && !zero_req && !same_pitch;

    beep_divider #(
        .NUM_W (NUM_W),
        .DEN_W (FREQ_W),
        .NUMER (NUMER)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (new_pitch),
        .den   (req_freq),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    // countdown loads on a same-pitch retrigger or when the speaker turns on
    always_comb begin
        dur_load = 1'b0;
        dur_val  = last_dur_q;
        if (same_pitch) begin
            dur_load = 1'b1;
            dur_val  = req_dur;
        end else if (state_q == ST_WR_ON && bus_ack) begin
            dur_load = 1'b1;
        end
    end

    beep_duration #(
        .DUR_W (DUR_W)
    ) u_dur (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dur_load),
        .load_val (dur_val),
        .run      (state_q == ST_SOUNDING),
        .tick     (tick),
        .expired  (dur_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (new_pitch) state_d = ST_DIVIDE;
            ST_DIVIDE:   if (div_done)  state_d = ST_WR_CTRL;
            ST_WR_CTRL:  if (bus_ack)   state_d = ST_WR_LO;
            ST_WR_LO:    if (bus_ack)   state_d = ST_WR_HI;
            ST_WR_HI:    if (bus_ack)   state_d = ST_RD_ON;
            ST_RD_ON:    if (bus_ack)   state_d = ST_WR_ON;
            ST_WR_ON:    if (bus_ack)   state_d = ST_SOUNDING;
            ST_SOUNDING: begin
                if (new_pitch)
                    state_d = ST_DIVIDE;
                else if (!accept && dur_expired)
                    state_d = ST_RD_OFF;
            end
            ST_RD_OFF:   if (bus_ack)   state_d = ST_WR_OFF;
            ST_WR_OFF:   if (bus_ack)   state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_freq_q <= '0;
            last_dur_q  <= '0;
            count_q     <= '0;
            spk_q       <= '0;
            active_q    <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            err_q <= zero_req;
            if (new_pitch) begin
                last_freq_q <= req_freq;
                last_dur_q  <= req_dur;
            end else if (same_pitch) begin
                last_dur_q  <= req_dur;
            end
            if (div_done)
                count_q <= div_quot[CNT_W-1:0];
            if ((state_q == ST_RD_ON || state_q == ST_RD_OFF) && bus_ack)
                spk_q <= bus_rdata;
            if (state_q == ST_WR_ON && bus_ack)
                active_q <= 1'b1;
            else if (state_q == ST_WR_OFF && bus_ack)
                active_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SOUNDING: req_ready = 1'b1;
            ST_DIVIDE: ;
            ST_WR_CTRL: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = CTRL_ADDR; bus_wdata = SQWAVE_CTRL;
            end
            ST_WR_LO: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = CNT2_ADDR; bus_wdata = count_q[7:0];
            end
            ST_WR_HI: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = CNT2_ADDR; bus_wdata = count_q[15:8];
            end
            ST_RD_ON, ST_RD_OFF: begin
                bus_req = 1'b1;
                bus_addr = SPK_PORT;
            end
            ST_WR_ON: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = SPK_PORT; bus_wdata = spk_q | SPK_BITS;
            end
            ST_WR_OFF: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = SPK_PORT; bus_wdata = spk_q & ~SPK_BITS;
            end
            default: ;
        endcase
    end

    assign beep_active = active_q;
    assign req_err     = err_q;

    logic unused_ok;
    assign unused_ok = div_busy;
endmodule

// File: rtl/tone_beep_ctrl_chk.sv
module tone_beep_ctrl_chk #(
    parameter logic [7:0] CTRL_ADDR = 8'h43,
    parameter logic [7:0] SPK_PORT  = 8'h61
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_freq,
    input logic        bus_req,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_ack,
    input logic        beep_active,
    input logic        req_err
);
    // R8
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we)
            && $stable(bus_addr) && $stable(bus_wdata)));

    // R9
    ready_when_bus_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);

    // R2
    ctrl_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == CTRL_ADDR) |-> (bus_wdata == 8'hB6));

    // R3
    on_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beep_active) |-> $past(bus_req && bus_ack && bus_we
            && bus_addr == SPK_PORT && bus_wdata[1:0] == 2'b11));

    // R4
    off_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beep_active) |-> $past(bus_req && bus_ack && bus_we
            && bus_addr == SPK_PORT && bus_wdata[1:0] == 2'b00));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_err) |-> $past(req_valid && req_ready && req_freq == 16'd0));
endmodule

bind tone_beep_ctrl tone_beep_ctrl_chk #(
    .CTRL_ADDR (TMR_BASE + 8'd3),
    .SPK_PORT  (SPK_PORT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_freq    (req_freq),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .beep_active (beep_active),
    .req_err     (req_err)
);

// File: tb/tb_tone_beep_ctrl.sv
module tb_tone_beep_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_freq = '0;
    logic [15:0] req_dur = '0;
    logic        tick = 1'b0;
    logic        bus_req, bus_we;
    logic [7:0]  bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        beep_active, req_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bus model state
    logic [7:0]  spk_reg = 8'hA4;
    logic [7:0]  mode_reg = '0;
    logic [7:0]  lo_reg = '0;
    logic [15:0] cnt_reg = '0;
    int          phase = 0;
    int          timer_prog = 0;
    int          txn = 0;
    int          order_err = 0;
    int          wait_n = 0;

    tone_beep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_freq(req_freq), .req_dur(req_dur), .tick(tick),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .beep_active(beep_active), .req_err(req_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bus responder with random latency, acting at the falling edge
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req && rst_n) begin
            if (wait_n == 0) begin
                bus_ack = 1'b1;
                txn++;
                wait_n = $urandom % 3;
                if (!bus_we) begin
                    if (bus_addr == 8'h61) bus_rdata = spk_reg;
                    else order_err++;
                end else if (bus_addr == 8'h61) begin
                    spk_reg = bus_wdata;
                end else if (bus_addr == 8'h43) begin
                    if (phase != 0) order_err++;
                    mode_reg = bus_wdata;
                    phase = 1;
                end else if (bus_addr == 8'h42) begin
                    if (phase == 1) begin
                        lo_reg = bus_wdata; phase = 2;
                    end else if (phase == 2) begin
                        cnt_reg = {bus_wdata, lo_reg}; phase = 0; timer_prog++;
                    end else order_err++;
                end else order_err++;
            end else begin
                wait_n--;
            end
        end
    end

    function automatic int exp_count(input int f);
        return ((1193182 + f / 2) / f) % 65536;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_req(input int f, input int d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_freq  = 16'(f);
        req_dur   = 16'(d);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        int t;
        logic [7:0] base;
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(bus_req == 0, "R10 bus_req", bus_req, 0);
        chk(beep_active == 0, "R10 beep_active", beep_active, 0);
        chk(req_err == 0, "R10 req_err", req_err, 0);
        chk(req_ready == 1, "R10 req_ready", req_ready, 1);

        // R1 R2 R3 R9: first tone at 1000 Hz
        send_req(1000, 5);
        @(negedge clk);
        chk(req_ready == 0, "R9 ready low while dividing", req_ready, 0);
        idle_cycles(80);
        chk(mode_reg == 8'hB6, "R2 control byte", mode_reg, 8'hB6);
        chk(cnt_reg == 16'(exp_count(1000)), "R1 count 1000Hz", cnt_reg, exp_count(1000));
        chk(spk_reg == 8'hA7, "R3 speaker on keeps bits", spk_reg, 8'hA7);
        chk(beep_active == 1, "R3 beep_active", beep_active, 1);

        // R4 countdown
        give_ticks(4);
        idle_cycles(10);
        chk(beep_active == 1, "R4 still on after 4 of 5", beep_active, 1);
        give_ticks(1);
        idle_cycles(30);
        chk(beep_active == 0, "R4 off after 5", beep_active, 0);
        chk(spk_reg == 8'hA4, "R4 speaker off keeps bits", spk_reg, 8'hA4);

        // R5 same-pitch retrigger
        spk_reg = 8'h58;
        send_req(440, 5);
        idle_cycles(80);
        chk(spk_reg == 8'h5B, "R3 speaker on other pattern", spk_reg, 8'h5B);
        w = timer_prog;
        t = txn;
        give_ticks(3);
        send_req(440, 5);
        idle_cycles(10);
        chk(timer_prog == w, "R5 no reprogram", timer_prog, w);
        chk(txn == t, "R5 no bus traffic", txn, t);
        give_ticks(4);
        idle_cycles(10);
        chk(beep_active == 1, "R5 countdown restarted", beep_active, 1);
        give_ticks(1);
        idle_cycles(30);
        chk(beep_active == 0, "R5 stops after new duration", beep_active, 0);
        chk(spk_reg == 8'h58, "R4 off pattern", spk_reg, 8'h58);

        // R6 different-pitch retrigger
        send_req(440, 50);
        idle_cycles(80);
        give_ticks(10);
        w = timer_prog;
        send_req(2000, 3);
        idle_cycles(80);
        chk(timer_prog == w + 1, "R6 reprogrammed", timer_prog, w + 1);
        chk(cnt_reg == 16'(exp_count(2000)), "R6 new count", cnt_reg, exp_count(2000));
        chk(beep_active == 1, "R6 still sounding", beep_active, 1);
        give_ticks(2);
        idle_cycles(10);
        chk(beep_active == 1, "R6 new duration running", beep_active, 1);
        give_ticks(1);
        idle_cycles(30);
        chk(beep_active == 0, "R6 stops after new duration", beep_active, 0);

        // R7 zero frequency while sounding
        send_req(880, 20);
        idle_cycles(80);
        t = txn;
        send_req(0, 3);
        @(negedge clk);
        chk(req_err == 1, "R7 err pulse", req_err, 1);
        @(negedge clk);
        chk(req_err == 0, "R7 err one cycle", req_err, 0);
        idle_cycles(40);
        chk(txn == t, "R7 no bus traffic", txn, t);
        chk(beep_active == 1, "R7 tone unaffected", beep_active, 1);
        give_ticks(20);
        idle_cycles(30);
        chk(beep_active == 0, "R4 off after 20", beep_active, 0);

        // R1 wrap-around cases
        send_req(18, 0);
        idle_cycles(80);
        chk(cnt_reg == 16'(exp_count(18)), "R1 count 18Hz wraps", cnt_reg, exp_count(18));
        idle_cycles(30);
        send_req(1, 0);
        idle_cycles(80);
        chk(cnt_reg == 16'(exp_count(1)), "R1 count 1Hz wraps", cnt_reg, exp_count(1));
        idle_cycles(30);
        chk(beep_active == 0, "R4 zero duration stops", beep_active, 0);

        // R1 R3 R4 random frequencies and speaker contents
        for (int k = 0; k < 20; k++) begin
            int f;
            int d;
            f = 19 + int'($urandom % 65517);
            d = 1 + int'($urandom % 4);
            base = 8'($urandom) & 8'hFC;
            spk_reg = base;
            send_req(f, d);
            idle_cycles(80);
            chk(cnt_reg == 16'(exp_count(f)), "R1 random count", cnt_reg, exp_count(f));
            chk(spk_reg == (base | 8'h03), "R3 random on", spk_reg, base | 8'h03);
            give_ticks(d);
            idle_cycles(30);
            chk(spk_reg == base, "R4 random off", spk_reg, base);
        end

        // R8 ordering seen by the bus model
        chk(order_err == 0, "R8 bus order", order_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule